// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns four asynchronous external interrupt pins into interrupt request flags for the interrupt controller on the processor side. Each pin first passes through a synchronizer. A sample register then takes the pin's level once per machine cycle. Comparing the synchronized level with that sample shows whether the pin rose, fell or stayed put during the last machine cycle. Each channel has its own two-bit mode that decides which of these changes count as a request.

A detected edge sets the channel's request flag on the machine-cycle strobe. The flag is offered on `irq_o` one machine cycle later. It stays there until the per-channel acknowledge input clears it, whether that pulse comes from the interrupt controller or from software. The mode register is loaded through a single write-only port. Its reset value disables every channel. Nothing is sampled and no flag is latched between strobes.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: Each of the four channels has its own request flag, and the flag of channel i appears only on `irq_o[i]`.
- R2: Channel i takes its mode from bits [2i+1:2i] of the mode register. The codes are 2'b00 off, 2'b01 falling edge, 2'b10 rising edge and 2'b11 both edges.
- R3: A channel whose mode is off never raises its flag, whatever its pin does.
- R4: A pin change that is held for at least three clocks before a strobe is detected on that strobe. The matching `irq_o` bit rises on the next strobe, and not on the first.
- R5: Once raised, an `irq_o` bit stays high over any number of strobes until its acknowledge bit is high on a clock edge. It is low from that edge on.
- R6: If a detected edge and the channel's acknowledge bit arrive on the same strobe, the edge wins. `irq_o` reads low after that strobe and high again after the next strobe.
- R7: A channel's sample register follows its pin even while the channel is off. Enabling a channel whose pin has been held steady therefore raises no request.
- R8: After reset the mode register is all zeros and `irq_o` is all zeros.
- R9: The pin is sampled only on the strobe. A pulse that begins and ends between two strobes raises no request.
- R10: An acknowledge bit affects only its own channel. Acknowledging a channel with nothing pending leaves the other flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_stb | input | 1 | One-clock strobe that marks each machine-cycle boundary |
| pin_i | input | NCH (4) | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Write enable for the mode register |
| cfg_wdata | input | 2*NCH (8) | Mode register write data, two bits per channel |
| ack_i | input | NCH (4) | Per-channel clear of the request flag |
| irq_o | output | NCH (4) | Pending request flags |

## Verification
Take a pin change made at a falling clock edge with at least three clock edges before the next strobe. The flag is set at that strobe, and `irq_o` follows at the strobe after it. The bench therefore drives the pins and then waits exactly two machine cycles before it compares. For the latency check it also samples after the first strobe, where the output must still be low. An acknowledge clears `irq_o` at the first clock edge on which it is high, so acknowledge checks sample at the falling edge right after a one-clock pulse. For the set-wins-over-clear case the bench samples after the strobe that carries both the edge and the clear, and again after the strobe that follows it. Every sample is taken at a falling edge, half a clock after the last edge that could change the result.

// File: rtl/eie_pkg.sv
package eie_pkg;

   localparam int MODE_W = 2;

   // per-channel edge selection, encoding is fixed by the mode register layout
   typedef enum logic [MODE_W-1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

endpackage

// File: rtl/eie_sync.sv
module eie_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("eie_sync: W must be at least 1");
   end
   if (STAGES == 1) begin : g_bad_stages
      $error("eie_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      // inputs are already synchronous to clk
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/eie_cfg_reg.sv
module eie_cfg_reg #(
   parameter int NCH = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic [NCH*eie_pkg::MODE_W-1:0] wdata_i,
   output logic [NCH*eie_pkg::MODE_W-1:0] cfg_o
);

   localparam int CFG_W = NCH * eie_pkg::MODE_W;

   logic [CFG_W-1:0] cfg_q;

   // write-only: no read path exists
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (we_i) cfg_q <= wdata_i;
   end

   assign cfg_o = cfg_q;

   // R8: the register changes only on a write
   a_r8_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/eie_channel.sv
module eie_channel
   import eie_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb_i,
   input  logic       pin_s_i,
   input  edge_mode_e mode_i,
   input  logic       ack_i,
   output logic       irq_o
);

   logic samp_q;
   logic flag_q;
   logic pend_q;
   logic rise;
   logic fall;
   logic hit;

   // level seen at the previous machine-cycle boundary; tracks even when off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     samp_q <= 1'b0;
      else if (stb_i) samp_q <= pin_s_i;
   end

   assign rise = pin_s_i & ~samp_q;
   assign fall = ~pin_s_i & samp_q;

   always_comb begin
      unique case (mode_i)
         EDGE_OFF:  hit = 1'b0;
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   // latch stage: set on a strobe with a hit, set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (stb_i && hit)   flag_q <= 1'b1;
      else if (ack_i)          flag_q <= 1'b0;
   end

   // presentation stage: one machine cycle behind the latch stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (ack_i)  pend_q <= 1'b0;
      else if (stb_i)  pend_q <= flag_q;
   end

   assign irq_o = pend_q;

   // R4: a latched flag reaches the output at the next strobe
   a_r4_flag_to_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && flag_q && !ack_i) |=> irq_o);

   // R6: a hit on the strobe survives a simultaneous clear
   a_r6_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && hit) |=> flag_q);

   // R5: clear drops the output at the next edge
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !irq_o);

   // R5: the flag persists without a clear
   a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !ack_i) |=> flag_q);

   // R9: the output can only rise on a strobe
   a_r9_rise_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && !irq_o) |=> !irq_o);

   // R3: a disabled channel never sets its flag
   a_r3_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == EDGE_OFF && !flag_q) |=> !flag_q);

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit #(
   parameter int NCH         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           mc_stb,
   input  logic [NCH-1:0]                 pin_i,
   input  logic                           cfg_we,
   input  logic [NCH*eie_pkg::MODE_W-1:0] cfg_wdata,
   input  logic [NCH-1:0]                 ack_i,
   output logic [NCH-1:0]                 irq_o
);

   localparam int CFG_W = NCH * eie_pkg::MODE_W;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("ext_irq_edge_unit: NCH must lie in 1..32");
   end

   logic [NCH-1:0]   pin_s;
   logic [CFG_W-1:0] cfg;

   eie_sync #(
      .W      (NCH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   eie_cfg_reg #(
      .NCH (NCH)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata),
      .cfg_o   (cfg)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      eie_channel u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .stb_i   (mc_stb),
         .pin_s_i (pin_s[i]),
         .mode_i  (eie_pkg::edge_mode_e'(cfg[i*eie_pkg::MODE_W +: eie_pkg::MODE_W])),
         .ack_i   (ack_i[i]),
         .irq_o   (irq_o[i])
      );
   end

endmodule

// File: tb/ext_irq_edge_unit_tb.sv
module ext_irq_edge_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_stb = 1'b0;
   logic [3:0] pin_i = '0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] ack_i = '0;
   logic [3:0] irq_o;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ext_irq_edge_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mc_stb    (mc_stb),
      .pin_i     (pin_i),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .ack_i     (ack_i),
      .irq_o     (irq_o)
   );

   // {mode register, new pin levels, expected irq after two machine cycles}
   localparam logic [15:0] VEC [12] = '{
      {8'hFF, 4'b0000, 4'b0000},  // R2 both, no change
      {8'hFF, 4'b0101, 4'b0101},  // R1 rising on 0,2
      {8'hFF, 4'b1111, 4'b1010},  // R1 rising on 1,3
      {8'h55, 4'b0011, 4'b1100},  // R2 falling
      {8'hAA, 4'b1100, 4'b1100},  // R2 rising only
      {8'h55, 4'b0011, 4'b1100},  // R2 falling only
      {8'h00, 4'b1100, 4'b0000},  // R3 all off
      {8'hAA, 4'b1100, 4'b0000},  // R7 enable with steady pins
      {8'h36, 4'b0011, 4'b0101},  // R2 mixed modes
      {8'h36, 4'b1100, 4'b0110},  // R2 mixed modes reversed
      {8'h11, 4'b0011, 4'b0100},  // R2 falling on ch0 and ch2
      {8'h11, 4'b0000, 4'b0001}   // R2 falling on ch0, ch1 off
   };

   task automatic check(input string req, input logic [3:0] exp);
      n_vec++;
      if (irq_o !== exp) begin
         n_bad++;
         $display("FAIL %s: irq_o=%b expected %b", req, irq_o, exp);
      end
   endtask

   // n machine cycles of 4 clocks; strobe on the last; ends at a falling edge
   task automatic mc(input int n, input logic [3:0] ack_on_stb = 4'b0000);
      repeat (n) begin
         repeat (3) begin
            @(negedge clk);
            mc_stb = 1'b0;
            ack_i  = '0;
         end
         @(negedge clk);
         mc_stb = 1'b1;
         ack_i  = ack_on_stb;
      end
      @(negedge clk);
      mc_stb = 1'b0;
      ack_i  = '0;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic pulse_ack(input logic [3:0] m);
      @(negedge clk);
      ack_i = m;
      @(negedge clk);
      ack_i = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: irq_o=%b expected completion", irq_o);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 reset outputs", 4'b0000);

      // R8/R3: reset mode register leaves every channel off
      pin_i = 4'b1111;
      mc(3);
      check("R8 reset modes disabled", 4'b0000);
      pin_i = 4'b0000;
      mc(3);
      check("R3 off channels after fall", 4'b0000);

      // vector table
      for (int v = 0; v < 12; v++) begin
         write_cfg(VEC[v][15:8]);
         pin_i = VEC[v][7:4];
         mc(2);
         check($sformatf("R2 vector %0d", v), VEC[v][3:0]);
         pulse_ack(4'b1111);
      end
      pulse_ack(4'b1111);
      check("R5 table cleanup", 4'b0000);

      // R4: latency of two strobes
      write_cfg(8'h03);
      pin_i = 4'b0001;
      mc(1);
      check("R4 not after first strobe", 4'b0000);
      mc(1);
      check("R4 after second strobe", 4'b0001);

      // R5: holds without acknowledge
      mc(3);
      check("R5 held over strobes", 4'b0001);

      // R10: acknowledge of another channel
      pulse_ack(4'b0010);
      check("R10 foreign ack ignored", 4'b0001);

      // R6: new edge and clear on the same strobe
      pin_i = 4'b0000;
      mc(1, 4'b0001);
      check("R6 cleared output after joint strobe", 4'b0000);
      mc(1);
      check("R6 set wins, output returns", 4'b0001);
      pulse_ack(4'b0001);
      check("R5 ack clears", 4'b0000);

      // R9: short pulse between strobes
      write_cfg(8'hFF);
      mc(1);
      @(negedge clk);
      pin_i = 4'b0100;
      @(negedge clk);
      pin_i = 4'b0000;
      mc(3);
      check("R9 pulse between strobes missed", 4'b0000);

      // R7: pin moves while off, then enable
      write_cfg(8'h00);
      pin_i = 4'b1010;
      mc(2);
      check("R7 off while pins rise", 4'b0000);
      write_cfg(8'hFF);
      mc(3);
      check("R7 enable without new edge", 4'b0000);

      // R7: enabled channel still sees the next real edge
      pin_i = 4'b0000;
      mc(2);
      check("R7 later edge detected", 4'b1010);

      finish_run();
   end

endmodule